// File: doc/BRIEF.md
# SPI Master Shift Engine with Block Framing

This block is the serial side of an SPI master. Words arrive on a valid/ready transmit stream. Each word is shifted out on MOSI, most significant bit first, under a programmable serial clock. The bits captured from MISO during the same clocks return on a valid/ready receive stream. One of several active-low select lines frames the traffic. Polarity, phase, word length and clock rate are plain configuration inputs. Software changes them only while the engine is idle.

Framing follows one of three rules:
- Word mode: every word gets a frame of its own.
- Block mode: the select line stays low while words keep arriving.
- Block mode with stall: the frame survives an empty transmit stream. The clock parks at its idle level until more data arrives. The frame closes only after a word tagged with the stop sideband has been shifted out.

A pause input holds back the start of any new word.

Back-pressure rules:
- Transmit: a word is taken on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` rises only when the engine can begin that word at once. `tx_data`, `tx_stop` and `tx_valid` must stay steady until that cycle.
- Receive: `rx_valid` stays high, with `rx_data` unchanged, until `rx_ready` is seen high. While a received word is still waiting, no new word starts. The engine stalls rather than drop data.

Top module: `spi_blk_master`

## Requirements
- R1: One bit takes E system clocks, where E = max(P·(D+1), 4). P is `cfg_prescale` (0 is treated as 1) and D is `cfg_divider`. The first floor(E/2) clocks of each bit sit at the idle clock level and the rest at the opposite level.
- R2: A word carries `cfg_size`+1 bits. These are taken from the low end of `tx_data` and sent most significant bit first.
- R3: `cfg_cpol` sets the idle SCLK level. When `cfg_cpha`=0, MOSI is valid before the leading edge and MISO is sampled on the leading edge. When `cfg_cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. All four combinations work.
- R4: With `cfg_block`=0, every accepted word gets its own frame. The select line returns high between words.
- R5: With `cfg_block`=1 and `cfg_stall`=0, words offered back to back share one frame. The frame ends at the first word boundary where `tx_valid` is low.
- R6: With `cfg_block`=1 and `cfg_stall`=1, an empty transmit stream keeps the select line low, SCLK at its idle level and `busy` high. The frame ends after a word accepted with `tx_stop`=1 has been sent.
- R7: While `cfg_pause`=1, no word starts, even with `tx_valid` high. Clearing it lets the pending word start.
- R8: Each sent word yields one receive word: the `cfg_size`+1 MISO bits, most significant first, right-aligned and zero-extended. An unaccepted receive word holds steady, and no further word starts until it is taken.
- R9: `busy` is high from the cycle the select line falls until the cycle it returns high.
- R10: During a frame, only the line `ss_n[cfg_sel]` is low. All other select lines stay high.
- R11: Outside frames, SCLK equals `cfg_cpol` and MOSI is low. Reset leaves every select line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prescale | input | PRE_W | Coarse clock prescale (0 treated as 1) |
| cfg_divider | input | DIV_W | Fine divider, rate factor is value+1 |
| cfg_size | input | log2(WORD_W) | Word length minus one |
| cfg_cpol | input | 1 | Idle level of SCLK |
| cfg_cpha | input | 1 | Sample on trailing edge when set |
| cfg_block | input | 1 | Keep select low across words |
| cfg_stall | input | 1 | In block mode, wait on an empty stream instead of ending |
| cfg_pause | input | 1 | Hold back the start of new words |
| cfg_sel | input | log2(SS_N) | Which select line frames traffic |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle |
| tx_data | input | WORD_W | Transmit word, right-aligned |
| tx_stop | input | 1 | Last word of a block frame |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes received word |
| rx_data | output | WORD_W | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_N | Active-low select lines |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the engine with 16-bit words and eight select lines. This reaches both the full word length (size 15) and a high select index (line 5), alongside short 5-bit and 8-bit words. Small prescale and divider values bring the rate clamp and an odd bit period within reach. Examples are a product of 1 that is lifted to 4, and a period of 9 that splits unevenly. A slave model follows SCLK in each of the four modes and streams its own pattern back. This lets every word be checked in both directions, together with frame counts, stall holding, pause holding and receive back-pressure.

// File: rtl/spi_blk_pkg.sv
`timescale 1ns/1ps
package spi_blk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // no frame, select high
    ST_PHA,   // first half of a bit, SCLK at idle level
    ST_PHB,   // second half of a bit, SCLK at active level
    ST_WAIT,  // block frame between words
    ST_TAIL   // hold select after last edge
  } eng_st_t;
endpackage

// File: rtl/spi_rate.sv
`timescale 1ns/1ps
// Bit period computation: product of prescale and divider+1, clamped to 4.
module spi_rate #(
  parameter int PRE_W = 7,
  parameter int DIV_W = 8,
  localparam int CNT_W = PRE_W + DIV_W + 1
) (
  input  logic [PRE_W-1:0] pre,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] half_a,
  output logic [CNT_W-1:0] half_b
);
  localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(4);

  logic [PRE_W-1:0] pre_eff;
  logic [DIV_W:0]   div_p1;
  logic [CNT_W-1:0] prod;
  logic [CNT_W-1:0] period;

  assign pre_eff = (pre == '0) ? PRE_W'(1) : pre;
  assign div_p1  = {1'b0, div} + {{DIV_W{1'b0}}, 1'b1};
  assign prod    = {{(CNT_W-PRE_W){1'b0}}, pre_eff} * {{(CNT_W-DIV_W-1){1'b0}}, div_p1};
  assign period  = (prod < MIN_PERIOD) ? MIN_PERIOD : prod;
  assign half_a  = period >> 1;
  assign half_b  = period - half_a;
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
// Transmit and receive shift registers with phase-dependent edge use.
module spi_shifter #(
  parameter int WORD_W = 16,
  localparam int SIZE_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic [SIZE_W-1:0] size,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              lead,
  input  logic              trail,
  input  logic              last,
  input  logic              clr,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  localparam logic [SIZE_W-1:0] TOP_IDX = SIZE_W'(WORD_W - 1);

  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] aligned;
  logic              mosi_q;

  assign aligned = load_word << (TOP_IDX - size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      mosi_q <= 1'b0;
    end else if (clr) begin
      mosi_q <= 1'b0;
    end else if (load) begin
      rx_sh <= '0;
      if (!cpha) begin
        mosi_q <= aligned[WORD_W-1];
        tx_sh  <= aligned << 1;
      end else begin
        tx_sh  <= aligned;
      end
    end else begin
      if (lead) begin
        if (cpha) begin
          mosi_q <= tx_sh[WORD_W-1];
          tx_sh  <= tx_sh << 1;
        end else begin
          rx_sh  <= {rx_sh[WORD_W-2:0], miso};
        end
      end
      if (trail) begin
        if (cpha) begin
          rx_sh <= {rx_sh[WORD_W-2:0], miso};
        end else if (!last) begin
          mosi_q <= tx_sh[WORD_W-1];
          tx_sh  <= tx_sh << 1;
        end
      end
    end
  end

  assign mosi    = mosi_q;
  // with trailing-edge sampling the final bit is taken in the word-end cycle
  assign rx_word = cpha ? {rx_sh[WORD_W-2:0], miso} : rx_sh;
endmodule

// File: rtl/spi_sel_decode.sv
`timescale 1ns/1ps
module spi_sel_decode #(
  parameter int SS_N = 8,
  localparam int SEL_W = $clog2(SS_N)
) (
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic [SS_N-1:0]  ss_n
);
  for (genvar g = 0; g < SS_N; g++) begin : g_line
    assign ss_n[g] = !(active && (sel == SEL_W'(g)));
  end
endmodule

// File: rtl/spi_blk_master.sv
`timescale 1ns/1ps
module spi_blk_master
  import spi_blk_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SS_N   = 8,
  parameter int PRE_W  = 7,
  parameter int DIV_W  = 8,
  localparam int SIZE_W = $clog2(WORD_W),
  localparam int SEL_W  = $clog2(SS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic [DIV_W-1:0]  cfg_divider,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_block,
  input  logic              cfg_stall,
  input  logic              cfg_pause,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_stop,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SS_N-1:0]   ss_n,
  output logic              busy
);
  localparam int CNT_W = PRE_W + DIV_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  eng_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  half_a, half_b;
  logic [SIZE_W-1:0] bits_left;
  logic              stop_q, sclk_q, ss_act;
  logic              rx_valid_q;
  logic [WORD_W-1:0] rx_data_q, rx_word;
  logic              can_start, take, cnt_done, lead, trail, last, clr;

  spi_rate #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_rate (
    .pre(cfg_prescale), .div(cfg_divider), .half_a(half_a), .half_b(half_b)
  );

  assign can_start = tx_valid && !cfg_pause && !rx_valid_q;
  assign take      = ((st == ST_IDLE) || (st == ST_WAIT)) && can_start;
  assign cnt_done  = (cnt == '0);
  assign lead      = (st == ST_PHA) && cnt_done;
  assign trail     = (st == ST_PHB) && cnt_done;
  assign last      = (bits_left == '0);
  assign clr       = (st == ST_TAIL) && cnt_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      stop_q    <= 1'b0;
      sclk_q    <= 1'b0;
      ss_act    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          sclk_q <= cfg_cpol;
          if (take) begin
            ss_act    <= 1'b1;
            st        <= ST_PHA;
            cnt       <= half_a - ONE;
            bits_left <= cfg_size;
            stop_q    <= tx_stop;
          end
        end
        ST_PHA: begin
          if (cnt_done) begin
            st     <= ST_PHB;
            cnt    <= half_b - ONE;
            sclk_q <= ~cfg_cpol;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_PHB: begin
          if (cnt_done) begin
            sclk_q <= cfg_cpol;
            if (last) begin
              if (!cfg_block || stop_q) begin
                st  <= ST_TAIL;
                cnt <= half_a - ONE;
              end else begin
                st <= ST_WAIT;
              end
            end else begin
              bits_left <= bits_left - SIZE_W'(1);
              st        <= ST_PHA;
              cnt       <= half_a - ONE;
            end
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_WAIT: begin
          if (take) begin
            st        <= ST_PHA;
            cnt       <= half_a - ONE;
            bits_left <= cfg_size;
            stop_q    <= tx_stop;
          end else if (!cfg_stall && !tx_valid) begin
            st  <= ST_TAIL;
            cnt <= half_a - ONE;
          end
        end
        ST_TAIL: begin
          if (cnt_done) begin
            st     <= ST_IDLE;
            ss_act <= 1'b0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else if (trail && last) begin
      rx_valid_q <= 1'b1;
      rx_data_q  <= rx_word;
    end else if (rx_ready) begin
      rx_valid_q <= 1'b0;
    end
  end

  spi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cpha(cfg_cpha), .size(cfg_size),
    .load(take), .load_word(tx_data), .lead(lead), .trail(trail),
    .last(last), .clr(clr), .miso(miso), .mosi(mosi), .rx_word(rx_word)
  );

  spi_sel_decode #(.SS_N(SS_N)) u_sel (
    .active(ss_act), .sel(cfg_sel), .ss_n(ss_n)
  );

  assign tx_ready = take;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign sclk     = sclk_q;
  assign busy     = (st != ST_IDLE);
endmodule

// File: rtl/spi_blk_master_chk.sv
`timescale 1ns/1ps
module spi_blk_master_chk #(
  parameter int WORD_W = 16,
  parameter int SS_N   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_cpol,
  input logic              cfg_pause,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              sclk,
  input logic              mosi,
  input logic [SS_N-1:0]   ss_n,
  input logic              busy
);
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n));

  a_r11_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (&ss_n) && $past(&ss_n) && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));

  a_r11_mosi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (&ss_n) |-> !mosi);

  a_r7_pause_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&ss_n) |-> !$past(cfg_pause));

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r4_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !(&ss_n));

  a_r9_busy_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !(&ss_n));
endmodule

bind spi_blk_master spi_blk_master_chk #(.WORD_W(WORD_W), .SS_N(SS_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_pause(cfg_pause),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
  .ss_n(ss_n), .busy(busy)
);

// File: tb/spi_blk_master_tb.sv
`timescale 1ns/1ps
module spi_blk_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] cfg_prescale = 7'd2;
  logic [7:0] cfg_divider = 8'd4;
  logic [3:0] cfg_size = 4'd7;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_block = 1'b0, cfg_stall = 1'b0, cfg_pause = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic tx_valid = 1'b0, tx_stop = 1'b0, rx_ready = 1'b1, miso = 1'b0;
  logic [15:0] tx_data = '0;
  logic tx_ready, rx_valid, sclk, mosi, busy;
  logic [15:0] rx_data;
  logic [7:0] ss_n;

  spi_blk_master u_dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0, frames = 0, sent_n = 0, slave_words = 0;
  int d_idx = 0, c_idx = 0, lead_idx = 0, period_meas = 0;
  realtime last_lead = 0.0;
  logic [15:0] s_out = '0, s_in = '0;
  logic [15:0] exp_mosi_q[$];
  logic [15:0] exp_rx_q[$];
  wire ss_all = &ss_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int n);
    return 16'h5A3C ^ (16'(n) * 16'h0D17);
  endfunction

  function automatic logic [15:0] msk(input logic [3:0] s);
    return 16'((32'h1 << (s + 1)) - 1);
  endfunction

  // slave model
  task drive_bit();
    if (d_idx == 0) s_out = pat(slave_words);
    miso = s_out[int'(cfg_size) - d_idx];
    d_idx = (d_idx == int'(cfg_size)) ? 0 : d_idx + 1;
  endtask

  task sample_bit();
    s_in = {s_in[14:0], mosi};
    if (c_idx == int'(cfg_size)) begin
      if (exp_mosi_q.size() == 0) chk(1'b0, "R2 unexpected word", int'(s_in), 0);
      else begin
        logic [15:0] e;
        e = exp_mosi_q.pop_front();
        chk(s_in == e, "R2 word on MOSI", int'(s_in), int'(e));
      end
      slave_words++;
      c_idx = 0;
      s_in = '0;
    end else c_idx++;
  endtask

  always @(negedge ss_all) begin
    frames++;
    d_idx = 0; c_idx = 0; lead_idx = 0; s_in = '0;
    if (!cfg_cpha) drive_bit();
  end

  always @(sclk) begin
    if (!ss_all) begin
      if (sclk != cfg_cpol) begin
        if (lead_idx != 0) period_meas = int'(($realtime - last_lead) / 5.0);
        last_lead = $realtime;
        lead_idx = (lead_idx == int'(cfg_size)) ? 0 : lead_idx + 1;
        if (cfg_cpha) drive_bit(); else sample_bit();
      end else begin
        if (cfg_cpha) sample_bit(); else drive_bit();
      end
    end
  end

  // receive monitor (scoreboard side)
  always begin
    @(negedge clk);
    #0.5;
    if (rx_valid && rx_ready) begin
      if (exp_rx_q.size() == 0) chk(1'b0, "R8 unexpected rx", int'(rx_data), 0);
      else begin
        logic [15:0] e;
        e = exp_rx_q.pop_front();
        chk(rx_data == e, "R8 received word", int'(rx_data), int'(e));
      end
    end
  end

  // driver: caller is at a negedge
  task automatic put_word(input logic [15:0] d, input bit stop);
    exp_mosi_q.push_back(d & msk(cfg_size));
    exp_rx_q.push_back(pat(sent_n) & msk(cfg_size));
    sent_n++;
    tx_data = d; tx_stop = stop; tx_valid = 1'b1;
    #0.5;
    while (!tx_ready) begin @(negedge clk); #0.5; end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (busy || tx_valid || exp_rx_q.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL R9 watchdog busy=%0d expected 0", busy);
    finish_run();
  end

  initial begin
    int fr0;
    logic [15:0] held, e0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state: R11, R9
    chk(ss_n == 8'hFF, "R11 reset select", int'(ss_n), 255);
    chk(!busy, "R9 reset busy", int'(busy), 0);
    chk(sclk == 1'b0 && !mosi, "R11 reset idle lines", int'({sclk, mosi}), 0);

    // mode 0, 8-bit, word mode, period 10 (R1, R3, R4)
    fr0 = frames;
    put_word(16'h0006, 1'b0);
    put_word(16'h1234, 1'b0);
    wait_done();
    chk(frames == fr0 + 2, "R4 one frame per word", frames - fr0, 2);
    chk(period_meas == 10, "R1 period 2x5", period_meas, 10);
    chk(sent_n == slave_words, "R3 mode 0 words seen", slave_words, sent_n);

    // mode 3, 16-bit, prescale 0 divider 0 -> clamp to 4, line 5 (R1, R3, R9, R10)
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_size = 4'd15; cfg_prescale = 7'd0; cfg_divider = 8'd0;
    cfg_sel = 3'd5;
    @(negedge clk);
    put_word(16'hBEEF, 1'b0);
    chk(ss_n == 8'hDF, "R10 only line 5 low", int'(ss_n), 223);
    chk(busy, "R9 busy in frame", int'(busy), 1);
    put_word(16'h8001, 1'b0);
    wait_done();
    chk(period_meas == 4, "R1 rate clamp", period_meas, 4);
    chk(sent_n == slave_words, "R3 mode 3 words seen", slave_words, sent_n);
    chk(sclk == 1'b1 && !mosi, "R11 idle with cpol 1", int'({sclk, mosi}), 2);

    // mode 1, 5-bit, block without stall, period 9 (R1, R5)
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_size = 4'd4; cfg_prescale = 7'd3; cfg_divider = 8'd2;
    cfg_block = 1'b1; cfg_sel = 3'd7;
    @(negedge clk);
    fr0 = frames;
    put_word(16'hFF15, 1'b0);
    put_word(16'h000A, 1'b0);
    put_word(16'h001F, 1'b0);
    wait_done();
    chk(frames == fr0 + 1, "R5 back-to-back words share frame", frames - fr0, 1);
    chk(ss_n == 8'hFF && !busy, "R5 frame ended when stream empty", int'(ss_n), 255);
    chk(period_meas == 9, "R1 odd period", period_meas, 9);

    // mode 2, 12-bit, block with stall (R6)
    cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_size = 4'd11; cfg_prescale = 7'd1; cfg_divider = 8'd5;
    cfg_stall = 1'b1; cfg_sel = 3'd2;
    @(negedge clk);
    fr0 = frames;
    put_word(16'h0ABC, 1'b0);
    put_word(16'h0123, 1'b0);
    repeat (250) @(negedge clk);
    chk(ss_n == 8'hFB, "R6 select held while empty", int'(ss_n), 251);
    chk(busy, "R6 busy while stalled", int'(busy), 1);
    chk(sclk == 1'b1, "R6 clock parked at idle level", int'(sclk), 1);
    chk(exp_rx_q.size() == 0, "R6 stalled words completed", exp_rx_q.size(), 0);
    put_word(16'h0FED, 1'b1);
    wait_done();
    chk(frames == fr0 + 1, "R6 stop word closes single frame", frames - fr0, 1);
    chk(ss_n == 8'hFF && sclk == 1'b1 && !mosi, "R11 idle after block", int'(ss_n), 255);

    // pause holds start (R7)
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_size = 4'd7; cfg_block = 1'b0; cfg_stall = 1'b0;
    cfg_pause = 1'b1;
    @(negedge clk);
    fr0 = frames;
    fork put_word(16'h00C3, 1'b0); join_none
    repeat (60) @(negedge clk);
    chk(ss_n == 8'hFF && !busy, "R7 no start while paused", int'(ss_n), 255);
    chk(tx_valid && exp_rx_q.size() == 1, "R7 word still pending", int'(tx_valid), 1);
    cfg_pause = 1'b0;
    wait_done();
    chk(frames == fr0 + 1, "R7 release starts word", frames - fr0, 1);

    // receive back-pressure (R8)
    rx_ready = 1'b0;
    fr0 = frames;
    e0 = pat(sent_n) & msk(4'd7);
    fork begin put_word(16'h0055, 1'b0); put_word(16'h00AA, 1'b0); end join_none
    repeat (150) @(negedge clk);
    chk(rx_valid && rx_data == e0, "R8 word waits for consumer", int'(rx_data), int'(e0));
    chk(frames == fr0 + 1, "R8 next word held back", frames - fr0, 1);
    held = rx_data;
    repeat (20) @(negedge clk);
    chk(rx_data == held && rx_valid, "R8 held word stable", int'(rx_data), int'(held));
    rx_ready = 1'b1;
    wait_done();
    chk(frames == fr0 + 2, "R8 second word after drain", frames - fr0, 2);
    chk(exp_mosi_q.size() == 0, "R2 all words shifted", exp_mosi_q.size(), 0);

    finish_run();
  end
endmodule